// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged 64-bit control registers of a processor core. The core reaches them through a single register-index port. A read returns data combinationally from the index. A write takes effect on the rising clock edge. Each index has its own write rule:
- a full-word store;
- a masked field, with every bit outside the field forced to zero;
- clear-on-any-write;
- read-only, where the value comes from hardware inputs;
- write-only.

A fault output flags any access in the wrong direction, and any access to an index the bank does not decode. The fault is valid in the same cycle as the access.

One register merges a free-running cycle counter into the low half of its read value. Writes to the translation-buffer invalidate controls do not keep readable state. Each one produces a registered single-cycle strobe toward the instruction-side or data-side translation buffer. A single-entry invalidate also carries the written address and the current address-space number. The translation buffers themselves, exception entry and instruction decode live elsewhere.

Top module: `pcr_bank`

## Requirements
- R1: A read of an undecoded index (29 to 63) or of a write-only index (20 to 28) returns zero and raises `fault_o` in the same cycle.
- R2: A write to a read-only index (17 to 19) or an undecoded index raises `fault_o` and leaves every stored register unchanged.
- R3: Reading index 17, 18 or 19 returns `intr_id_i`, `mm_stat_i` or `pte_temp_i` respectively, without a fault.
- R4: Reading index 14 returns the stored upper 32 bits joined with the low 32 bits of a free-running counter. The counter is zero in the first cycle after reset and adds one on every clock edge.
- R5: A write to index 5 (exception address) stores the data with bit 1 forced to zero.
- R6: Indices 6 and 7 (trap request and trap enable) keep only bits [3:0]. Index 8 (interrupt priority level) keeps only bits [4:0].
- R7: Indices 9 and 10 (current mode) keep only bits [4:3]. Index 11 (software interrupt request) keeps only bits [18:4].
- R8: Any write to index 12 or 13 (exception summary and exception mask) leaves it reading zero, whatever the data written.
- R9: A write to index 23 or 24 raises the instruction-side flush-all or flush-by-process strobe. A write to index 26 or 27 raises the matching data-side strobe. The strobe is high for exactly the one cycle after the write edge.
- R10: A write to index 25 or 28 raises the instruction-side or data-side address-flush strobe for one cycle. During that cycle `flush_va_o` holds the written data. `flush_asn_o` holds the address-space number: bits [10:4] of index 15 (instruction side, write mask 0x7F0), or bits [63:57] of index 16 (data side, write mask 0xFE00_0000_0000_0000).
- R11: Scratch indices 0 to 3 and base index 4 store and return the full 64-bit word.
- R12: A synchronous active-high reset clears every stored register, the cycle counter and all strobes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read access this cycle |
| wr_en | input | 1 | Write access this cycle |
| idx | input | 6 | Register index |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, combinational from `idx` |
| fault_o | output | 1 | Access fault, same cycle |
| intr_id_i | input | 64 | Hardware value for read-only index 17 |
| mm_stat_i | input | 64 | Hardware value for read-only index 18 |
| pte_temp_i | input | 64 | Hardware value for read-only index 19 |
| iflush_all_o | output | 1 | Instruction-side flush-all strobe |
| iflush_proc_o | output | 1 | Instruction-side flush-by-process strobe |
| iflush_addr_o | output | 1 | Instruction-side address-flush strobe |
| dflush_all_o | output | 1 | Data-side flush-all strobe |
| dflush_proc_o | output | 1 | Data-side flush-by-process strobe |
| dflush_addr_o | output | 1 | Data-side address-flush strobe |
| flush_va_o | output | 64 | Address that goes with an address-flush strobe |
| flush_asn_o | output | 7 | Address-space number that goes with an address-flush strobe |

## Verification
A wrong write mask or a missed clear stays hidden until that index is read back. The bench therefore reads each index in the cycle right after its write, so the first stale bit shows on `rd_data` one cycle after the edge that stored it. A write that leaks past a fault would alter a neighbour register, and the bench reads a victim register back after every rejected write. A strobe that is decoded wrongly, is late, or lasts too long shows up one cycle after the write, when the bench samples all six strobes together and samples them again in the following cycle.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    parameter int IDX_W   = 6;
    parameter int DATA_W  = 64;
    parameter int ASN_W   = 7;
    parameter int NUM_SCR = 4;
    parameter int NUM_IDX = 29;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

    typedef enum logic [2:0] {
        FX_NONE, FX_I_ALL, FX_I_PROC, FX_I_ONE, FX_D_ALL, FX_D_PROC, FX_D_ONE
    } fx_e;

    typedef struct packed {
        acc_e              acc;
        logic [DATA_W-1:0] keep;
        logic              clr;
        logic              cyc;
        fx_e               fx;
    } rule_t;

    localparam logic [IDX_W-1:0] IX_BASE  = 6'd4;
    localparam logic [IDX_W-1:0] IX_EADDR = 6'd5;
    localparam logic [IDX_W-1:0] IX_TREQ  = 6'd6;
    localparam logic [IDX_W-1:0] IX_TEN   = 6'd7;
    localparam logic [IDX_W-1:0] IX_PRIO  = 6'd8;
    localparam logic [IDX_W-1:0] IX_IMODE = 6'd9;
    localparam logic [IDX_W-1:0] IX_DMODE = 6'd10;
    localparam logic [IDX_W-1:0] IX_SWINT = 6'd11;
    localparam logic [IDX_W-1:0] IX_ESUM  = 6'd12;
    localparam logic [IDX_W-1:0] IX_EMASK = 6'd13;
    localparam logic [IDX_W-1:0] IX_CYC   = 6'd14;
    localparam logic [IDX_W-1:0] IX_IASN  = 6'd15;
    localparam logic [IDX_W-1:0] IX_DASN  = 6'd16;
    localparam logic [IDX_W-1:0] IX_INTID = 6'd17;
    localparam logic [IDX_W-1:0] IX_MMST  = 6'd18;
    localparam logic [IDX_W-1:0] IX_PTET  = 6'd19;
    localparam logic [IDX_W-1:0] IX_ICLR  = 6'd20;
    localparam logic [IDX_W-1:0] IX_DCFL  = 6'd21;
    localparam logic [IDX_W-1:0] IX_ICFL  = 6'd22;
    localparam logic [IDX_W-1:0] IX_IALL  = 6'd23;
    localparam logic [IDX_W-1:0] IX_IPROC = 6'd24;
    localparam logic [IDX_W-1:0] IX_IONE  = 6'd25;
    localparam logic [IDX_W-1:0] IX_DALL  = 6'd26;
    localparam logic [IDX_W-1:0] IX_DPROC = 6'd27;
    localparam logic [IDX_W-1:0] IX_DONE  = 6'd28;

    localparam logic [DATA_W-1:0] M_FULL  = '1;
    localparam logic [DATA_W-1:0] M_EADDR = ~64'h2;
    localparam logic [DATA_W-1:0] M_TRAP  = 64'hF;
    localparam logic [DATA_W-1:0] M_PRIO  = 64'h1F;
    localparam logic [DATA_W-1:0] M_MODE  = 64'h18;
    localparam logic [DATA_W-1:0] M_SWINT = 64'h7FFF0;
    localparam logic [DATA_W-1:0] M_IASN  = 64'h7F0;
    localparam logic [DATA_W-1:0] M_DASN  = 64'hFE00_0000_0000_0000;

    localparam int IASN_LO = 4;
    localparam int DASN_LO = 57;

    function automatic rule_t mk(acc_e a, logic [DATA_W-1:0] k, logic c, logic y, fx_e f);
        rule_t r;
        r.acc  = a;
        r.keep = k;
        r.clr  = c;
        r.cyc  = y;
        r.fx   = f;
        return r;
    endfunction

    function automatic rule_t rule_of(input logic [IDX_W-1:0] ix);
        rule_t r;
        r = mk(ACC_NONE, '0, 1'b0, 1'b0, FX_NONE);
        if (int'(ix) < NUM_SCR) begin
            r = mk(ACC_RW, M_FULL, 1'b0, 1'b0, FX_NONE);
        end else begin
            case (ix)
                IX_BASE:  r = mk(ACC_RW, M_FULL,  1'b0, 1'b0, FX_NONE);
                IX_EADDR: r = mk(ACC_RW, M_EADDR, 1'b0, 1'b0, FX_NONE);
                IX_TREQ,
                IX_TEN:   r = mk(ACC_RW, M_TRAP,  1'b0, 1'b0, FX_NONE);
                IX_PRIO:  r = mk(ACC_RW, M_PRIO,  1'b0, 1'b0, FX_NONE);
                IX_IMODE,
                IX_DMODE: r = mk(ACC_RW, M_MODE,  1'b0, 1'b0, FX_NONE);
                IX_SWINT: r = mk(ACC_RW, M_SWINT, 1'b0, 1'b0, FX_NONE);
                IX_ESUM,
                IX_EMASK: r = mk(ACC_RW, '0,      1'b1, 1'b0, FX_NONE);
                IX_CYC:   r = mk(ACC_RW, M_FULL,  1'b0, 1'b1, FX_NONE);
                IX_IASN:  r = mk(ACC_RW, M_IASN,  1'b0, 1'b0, FX_NONE);
                IX_DASN:  r = mk(ACC_RW, M_DASN,  1'b0, 1'b0, FX_NONE);
                IX_INTID,
                IX_MMST,
                IX_PTET:  r = mk(ACC_RO, '0,      1'b0, 1'b0, FX_NONE);
                IX_ICLR,
                IX_DCFL,
                IX_ICFL:  r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_NONE);
                IX_IALL:  r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_I_ALL);
                IX_IPROC: r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_I_PROC);
                IX_IONE:  r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_I_ONE);
                IX_DALL:  r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_D_ALL);
                IX_DPROC: r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_D_PROC);
                IX_DONE:  r = mk(ACC_WO, '0,      1'b0, 1'b0, FX_D_ONE);
                default:  r = mk(ACC_NONE, '0,    1'b0, 1'b0, FX_NONE);
            endcase
        end
        return r;
    endfunction

    function automatic logic is_stored(input int ix);
        return rule_of(IDX_W'(ix)).acc == ACC_RW;
    endfunction

endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
    import pcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    output rule_t            rule,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             fault
);

    always_comb begin
        rule  = rule_of(idx);
        rd_ok = (rule.acc == ACC_RW) || (rule.acc == ACC_RO);
        wr_ok = (rule.acc == ACC_RW) || (rule.acc == ACC_WO);
        fault = (rd_en && !rd_ok) || (wr_en && !wr_ok);
    end

    // R1 / R2: a fault only appears while an access is presented
    assert_fault_needs_access_R2: assert property (@(posedge clk) disable iff (rst)
        fault |-> (rd_en || wr_en));

    // R2: writes to read-only indices always fault
    assert_ro_write_faults_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx >= IX_INTID && idx <= IX_PTET) |-> fault);

endmodule

// File: rtl/pcr_cycle.sv
module pcr_cycle
    import pcr_pkg::*;
#(
    parameter int CNT_W = HALF_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    // R4: the counter advances by exactly one per cycle
    assert_cycle_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/pcr_store.sv
module pcr_store
    import pcr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            wr_ok,
    input  logic [IDX_W-1:0]                idx,
    input  logic [DATA_W-1:0]               wr_data,
    input  rule_t                           rule,
    output logic [NUM_IDX-1:0][DATA_W-1:0]  q
);

    logic [DATA_W-1:0] wval;
    logic              wfire;

    always_comb begin
        wfire = wr_en && wr_ok && (rule.acc == ACC_RW);
        wval  = rule.clr ? '0 : (wr_data & rule.keep);
    end

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_reg
        if (is_stored(g)) begin : g_keep
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)                               r <= '0;
                else if (wfire && idx == IDX_W'(g))    r <= wval;
            end
            assign q[g] = r;
        end else begin : g_none
            assign q[g] = '0;
        end
    end

    // R2: a rejected write leaves all stored state untouched
    assert_bad_write_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ok) |=> $stable(q));

    // R5: exception address bit 1 never holds a one
    assert_eaddr_bit1_R5: assert property (@(posedge clk) disable iff (rst)
        q[IX_EADDR][1] == 1'b0);

    // R6: priority level holds nothing above bit 4
    assert_prio_field_R6: assert property (@(posedge clk) disable iff (rst)
        q[IX_PRIO][DATA_W-1:5] == '0);

    // R7: software interrupt request holds nothing outside [18:4]
    assert_swint_field_R7: assert property (@(posedge clk) disable iff (rst)
        (q[IX_SWINT] & ~M_SWINT) == '0);

    // R8: a write to the summary register leaves it zero
    assert_sum_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IX_ESUM) |=> q[IX_ESUM] == '0);

endmodule

// File: rtl/pcr_strobe.sv
module pcr_strobe
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  fx_e               fx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ASN_W-1:0]  asn_i,
    input  logic [ASN_W-1:0]  asn_d,
    output logic              i_all,
    output logic              i_proc,
    output logic              i_addr,
    output logic              d_all,
    output logic              d_proc,
    output logic              d_addr,
    output logic [DATA_W-1:0] va,
    output logic [ASN_W-1:0]  asn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            i_all  <= 1'b0;
            i_proc <= 1'b0;
            i_addr <= 1'b0;
            d_all  <= 1'b0;
            d_proc <= 1'b0;
            d_addr <= 1'b0;
            va     <= '0;
            asn    <= '0;
        end else begin
            i_all  <= fire && fx == FX_I_ALL;
            i_proc <= fire && fx == FX_I_PROC;
            i_addr <= fire && fx == FX_I_ONE;
            d_all  <= fire && fx == FX_D_ALL;
            d_proc <= fire && fx == FX_D_PROC;
            d_addr <= fire && fx == FX_D_ONE;
            if (fire && fx == FX_I_ONE) begin
                va  <= wr_data;
                asn <= asn_i;
            end else if (fire && fx == FX_D_ONE) begin
                va  <= wr_data;
                asn <= asn_d;
            end
        end
    end

    // R9 / R10: at most one strobe per cycle
    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({i_all, i_proc, i_addr, d_all, d_proc, d_addr}));

    // R9: strobes follow a write and stay only one cycle
    assert_iall_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (i_all && !(fire && fx == FX_I_ALL)) |=> !i_all);
    assert_dall_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && d_all) |-> $past(fire));

    // R10: address flush carries the data written in the cycle before
    assert_iaddr_va_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && fx == FX_I_ONE) |=> (i_addr && va == $past(wr_data)));

endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault_o,
    input  logic [DATA_W-1:0] intr_id_i,
    input  logic [DATA_W-1:0] mm_stat_i,
    input  logic [DATA_W-1:0] pte_temp_i,
    output logic              iflush_all_o,
    output logic              iflush_proc_o,
    output logic              iflush_addr_o,
    output logic              dflush_all_o,
    output logic              dflush_proc_o,
    output logic              dflush_addr_o,
    output logic [DATA_W-1:0] flush_va_o,
    output logic [ASN_W-1:0]  flush_asn_o
);

    rule_t                          rule;
    logic                           rd_ok;
    logic                           wr_ok;
    logic [NUM_IDX-1:0][DATA_W-1:0] q;
    logic [HALF_W-1:0]              cnt;
    logic [DATA_W-1:0]              ro_val;
    logic [DATA_W-1:0]              iasn_reg;
    logic [DATA_W-1:0]              dasn_reg;

    pcr_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .idx   (idx),
        .rule  (rule),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok),
        .fault (fault_o)
    );

    pcr_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ok   (wr_ok),
        .idx     (idx),
        .wr_data (wr_data),
        .rule    (rule),
        .q       (q)
    );

    pcr_cycle #(.CNT_W(HALF_W)) u_cyc (
        .clk (clk),
        .rst (rst),
        .cnt (cnt)
    );

    assign iasn_reg = q[IX_IASN];
    assign dasn_reg = q[IX_DASN];

    pcr_strobe u_stb (
        .clk     (clk),
        .rst     (rst),
        .fire    (wr_en && wr_ok),
        .fx      (rule.fx),
        .wr_data (wr_data),
        .asn_i   (iasn_reg[IASN_LO +: ASN_W]),
        .asn_d   (dasn_reg[DASN_LO +: ASN_W]),
        .i_all   (iflush_all_o),
        .i_proc  (iflush_proc_o),
        .i_addr  (iflush_addr_o),
        .d_all   (dflush_all_o),
        .d_proc  (dflush_proc_o),
        .d_addr  (dflush_addr_o),
        .va      (flush_va_o),
        .asn     (flush_asn_o)
    );

    always_comb begin
        case (idx)
            IX_INTID: ro_val = intr_id_i;
            IX_MMST:  ro_val = mm_stat_i;
            IX_PTET:  ro_val = pte_temp_i;
            default:  ro_val = '0;
        endcase
    end

    always_comb begin
        rd_data = '0;
        if (rule.acc == ACC_RW) begin
            if (rule.cyc) rd_data = {q[idx][DATA_W-1:HALF_W], cnt};
            else          rd_data = q[idx];
        end else if (rule.acc == ACC_RO) begin
            rd_data = ro_val;
        end
    end

    // R1: a faulting read returns zero
    assert_bad_read_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && fault_o) |-> rd_data == '0);

    // R3: read-only reads pass the hardware value through
    assert_ro_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IX_MMST) |-> (rd_data == mm_stat_i && !fault_o));

    // R12: strobes are quiet in the cycle after reset
    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(rst) |-> !(iflush_all_o || dflush_all_o || iflush_addr_o || dflush_addr_o));

endmodule

// File: tb/pcr_bank_bench.sv
module pcr_bank_bench;
    import pcr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              fault_o;
    logic [DATA_W-1:0] intr_id_i  = 64'h1111_2222_3333_4444;
    logic [DATA_W-1:0] mm_stat_i  = 64'hA5A5_0000_FFFF_0001;
    logic [DATA_W-1:0] pte_temp_i = 64'h0BAD_F00D_1234_5678;
    logic              iflush_all_o, iflush_proc_o, iflush_addr_o;
    logic              dflush_all_o, dflush_proc_o, dflush_addr_o;
    logic [DATA_W-1:0] flush_va_o;
    logic [ASN_W-1:0]  flush_asn_o;

    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;
    logic [31:0] ref_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) ref_cnt <= rst ? 32'd0 : ref_cnt + 32'd1;

    pcr_bank u_pcr_bank (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .idx(idx),
        .wr_data(wr_data), .rd_data(rd_data), .fault_o(fault_o),
        .intr_id_i(intr_id_i), .mm_stat_i(mm_stat_i), .pte_temp_i(pte_temp_i),
        .iflush_all_o(iflush_all_o), .iflush_proc_o(iflush_proc_o),
        .iflush_addr_o(iflush_addr_o), .dflush_all_o(dflush_all_o),
        .dflush_proc_o(dflush_proc_o), .dflush_addr_o(dflush_addr_o),
        .flush_va_o(flush_va_o), .flush_asn_o(flush_asn_o)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ix, input logic [DATA_W-1:0] d, output logic f);
        @(negedge clk);
        idx = IDX_W'(ix); wr_data = d; wr_en = 1'b1;
        #1 f = fault_o;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input int ix, output logic [DATA_W-1:0] d, output logic f);
        @(negedge clk);
        idx = IDX_W'(ix); rd_en = 1'b1;
        #1 d = rd_data; f = fault_o;
        rd_en = 1'b0;
    endtask

    function automatic logic [5:0] strobes();
        return {iflush_all_o, iflush_proc_o, iflush_addr_o, dflush_all_o, dflush_proc_o, dflush_addr_o};
    endfunction

    task automatic t_reset;
        logic [DATA_W-1:0] d; logic f;
        rd(0, d, f);   chk("R12 scratch after reset", d, '0);
        rd(8, d, f);   chk("R12 prio after reset", d, '0);
        chk("R12 strobes after reset", 64'(strobes()), '0);
        rd(14, d, f);
        chk("R12 cycle low half counts from reset", d, {32'd0, ref_cnt});
    endtask

    task automatic t_full_word;
        logic [DATA_W-1:0] d; logic f;
        for (int i = 0; i < 5; i++) begin
            wr(i, 64'hDEAD_BEEF_0000_0000 | 64'(i * 7 + 1), f);
            chk("R11 write no fault", 64'(f), 64'd0);
            rd(i, d, f);
            chk("R11 full word", d, 64'hDEAD_BEEF_0000_0000 | 64'(i * 7 + 1));
        end
    endtask

    task automatic t_masks;
        logic [DATA_W-1:0] d; logic f;
        wr(5, '1, f);  rd(5, d, f);  chk("R5 exc addr bit1 clear", d, ~64'h2);
        wr(6, '1, f);  rd(6, d, f);  chk("R6 trap req", d, 64'hF);
        wr(7, 64'h35, f); rd(7, d, f); chk("R6 trap enable", d, 64'h5);
        wr(8, '1, f);  rd(8, d, f);  chk("R6 prio", d, 64'h1F);
        wr(9, '1, f);  rd(9, d, f);  chk("R7 mode i", d, 64'h18);
        wr(10, 64'h10, f); rd(10, d, f); chk("R7 mode d", d, 64'h10);
        wr(11, '1, f); rd(11, d, f); chk("R7 swint", d, 64'h7FFF0);
    endtask

    task automatic t_clear;
        logic [DATA_W-1:0] d; logic f;
        wr(12, '1, f); rd(12, d, f); chk("R8 summary cleared", d, '0);
        chk("R8 no fault", 64'(f), 64'd0);
        wr(13, 64'h55, f); rd(13, d, f); chk("R8 mask cleared", d, '0);
    endtask

    task automatic t_bad_access;
        logic [DATA_W-1:0] d; logic f;
        rd(40, d, f); chk("R1 unknown read data", d, '0); chk("R1 unknown read fault", 64'(f), 64'd1);
        rd(21, d, f); chk("R1 write-only read data", d, '0); chk("R1 write-only read fault", 64'(f), 64'd1);
        rd(23, d, f); chk("R1 flush ctl read fault", 64'(f), 64'd1);
        wr(3, 64'h1234, f);
        wr(17, '1, f); chk("R2 ro write fault", 64'(f), 64'd1);
        rd(3, d, f);   chk("R2 victim unchanged", d, 64'h1234);
        wr(63, '1, f); chk("R2 unknown write fault", 64'(f), 64'd1);
        rd(3, d, f);   chk("R2 victim unchanged 2", d, 64'h1234);
        chk("R2 no strobe on bad write", 64'(strobes()), '0);
    endtask

    task automatic t_ro;
        logic [DATA_W-1:0] d; logic f;
        rd(17, d, f); chk("R3 intr id", d, intr_id_i); chk("R3 no fault", 64'(f), 64'd0);
        rd(18, d, f); chk("R3 mm stat", d, mm_stat_i);
        rd(19, d, f); chk("R3 pte temp", d, pte_temp_i);
    endtask

    task automatic t_cycle;
        logic [DATA_W-1:0] d; logic f;
        wr(14, 64'hCAFE_0001_FFFF_FFFF, f);
        rd(14, d, f); chk("R4 cycle merge", d, {32'hCAFE_0001, ref_cnt});
        repeat (5) @(negedge clk);
        rd(14, d, f); chk("R4 cycle advances", d, {32'hCAFE_0001, ref_cnt});
    endtask

    task automatic t_strobes;
        logic f;
        wr(23, 64'h99, f); chk("R9 i all strobe", 64'(strobes()), 64'b100000);
        @(negedge clk); #1 chk("R9 i all one cycle", 64'(strobes()), '0);
        wr(24, 64'h1, f); chk("R9 i proc strobe", 64'(strobes()), 64'b010000);
        wr(26, 64'h1, f); chk("R9 d all strobe", 64'(strobes()), 64'b000100);
        wr(27, 64'h1, f); chk("R9 d proc strobe", 64'(strobes()), 64'b000010);
        @(negedge clk); #1 chk("R9 d proc one cycle", 64'(strobes()), '0);
        wr(20, 64'h1, f); chk("R9 intr clear no strobe", 64'(strobes()), '0);
        chk("R9 intr clear no fault", 64'(f), 64'd0);
    endtask

    task automatic t_addr_flush;
        logic [DATA_W-1:0] d; logic f;
        wr(15, '1, f); rd(15, d, f); chk("R10 i asn mask", d, 64'h7F0);
        wr(15, 64'h0000_0000_0000_05A0, f);
        wr(25, 64'h0000_7FFF_1234_0000, f);
        chk("R10 i addr strobe", 64'(strobes()), 64'b001000);
        chk("R10 i va", flush_va_o, 64'h0000_7FFF_1234_0000);
        chk("R10 i asn", 64'(flush_asn_o), 64'h5A);
        @(negedge clk); #1 chk("R10 i addr one cycle", 64'(strobes()), '0);
        wr(16, '1, f); rd(16, d, f); chk("R10 d asn mask", d, 64'hFE00_0000_0000_0000);
        wr(16, 64'h6600_0000_0000_0000, f);
        wr(28, 64'h0000_0000_0000_8000, f);
        chk("R10 d addr strobe", 64'(strobes()), 64'b000001);
        chk("R10 d va", flush_va_o, 64'h8000);
        chk("R10 d asn", 64'(flush_asn_o), 64'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_word();
        t_masks();
        t_clear();
        t_bad_access();
        t_ro();
        t_cycle();
        t_strobes();
        t_addr_flush();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule